// File: doc/BRIEF.md
# Conversion Result Sign Formatter

This block turns a raw converter sample of programmable resolution (8, 10, 12, 14 or 16 bits, right-aligned in a 16-bit input) into a 16-bit result word. Whether the sample is read as signed or as unsigned depends on a two-bit sign policy code and on a per-sample flag that marks the channel as single-ended or differential. A signed sample narrower than 16 bits has its top valid bit copied up through bit 15. An unsigned sample is padded with zeros.

Alongside the result, the block builds a 32-bit last-sample word. Its low half holds the formatted result. When the tag enable is set, the sample's channel number goes into a 4-bit field. When the tag enable is clear, that field is zero. Both words are registered and come with a one-cycle valid strobe.

Top module: `res_sign_fmt`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `result` and `last_word` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: The policy code `sign_policy` selects the interpretation. With code 0, single-ended (`is_diff`=0) is unsigned and differential is signed. With code 1, single-ended is signed and differential is unsigned. Code 2 makes every sample unsigned. Code 3 makes every sample signed.
- R4: The resolution code `res_sel` selects the width: 0=8, 1=10, 2=12, 3=14, 4=16 bits. Codes 5 to 7 are treated as 16 bits. Input bits above the selected width are ignored.
- R5: A signed sample narrower than 16 bits has its top valid bit copied into all higher bits of `result`. For example, at 12 bits 0xF43 gives 0xFF43 and 0x467 gives 0x0467.
- R6: An unsigned sample narrower than 16 bits gives `result` with zeros above the top valid bit.
- R7: At 16 bits, `result` equals the raw input in both signed and unsigned interpretation.
- R8: In `last_word`, bits 27:24 hold `chan` when `tag_en`=1 and zero when `tag_en`=0. Bits 15:0 equal `result`. All other bits are zero.
- R9: While `in_valid` is low, `result` and `last_word` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample present |
| raw | input | 16 | Raw sample, right-aligned |
| res_sel | input | 3 | Resolution code |
| sign_policy | input | 2 | Signed/unsigned policy code |
| is_diff | input | 1 | 1 = differential channel |
| chan | input | 4 | Channel number |
| tag_en | input | 1 | Insert channel number into last_word |
| out_valid | output | 1 | Result strobe |
| result | output | 16 | Formatted 16-bit result |
| last_word | output | 32 | Tagged last-sample word |

## Verification
Every result is due one clock edge after its input is presented: `out_valid`, `result` and `last_word` all change at that edge. The bench drives inputs on the falling edge. It then waits for the next rising edge and samples on the following falling edge, comparing against a reference model computed in bench functions. Cycles with `in_valid` low are checked to show a low strobe and results held from the last valid sample.

// File: rtl/res_sign_fmt_pkg.sv
package res_sign_fmt_pkg;
  parameter int RAW_W  = 16;
  parameter int CHAN_W = 4;
  parameter int WORD_W = 32;
  parameter int TAG_LSB = 24;

  typedef enum logic [1:0] {
    POL_SE_U_DF_S = 2'd0,
    POL_SE_S_DF_U = 2'd1,
    POL_ALL_U     = 2'd2,
    POL_ALL_S     = 2'd3
  } sign_policy_e;

  typedef enum logic [2:0] {
    RES_8  = 3'd0,
    RES_10 = 3'd1,
    RES_12 = 3'd2,
    RES_14 = 3'd3,
    RES_16 = 3'd4
  } res_code_e;
endpackage

// File: rtl/res_sign_decide.sv
module res_sign_decide
  import res_sign_fmt_pkg::*;
(
  input  logic [1:0] policy,
  input  logic       is_diff,
  output logic       is_signed
);
  always_comb begin
    unique case (sign_policy_e'(policy))
      POL_SE_U_DF_S: is_signed = is_diff;
      POL_SE_S_DF_U: is_signed = ~is_diff;
      POL_ALL_U:     is_signed = 1'b0;
      default:       is_signed = 1'b1;
    endcase
  end
endmodule

// File: rtl/res_width_extend.sv
module res_width_extend
  import res_sign_fmt_pkg::*;
#(
  parameter int W = RAW_W,
  parameter int NUM_RES = 5
) (
  input  logic [W-1:0] raw,
  input  logic [2:0]   res_sel,
  input  logic         is_signed,
  output logic [W-1:0] ext
);
  localparam int MIN_W = W - 2 * (NUM_RES - 1);

  logic [W-1:0] cand [NUM_RES];

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    localparam int RW = MIN_W + 2 * g;
    if (RW >= W) begin : g_full
      assign cand[g] = raw;
    end else begin : g_part
      logic fill;
      assign fill = is_signed & raw[RW-1];
      assign cand[g] = {{(W-RW){fill}}, raw[RW-1:0]};
    end
  end

  always_comb begin
    if (res_sel < 3'(NUM_RES)) ext = cand[res_sel];
    else                       ext = cand[NUM_RES-1];
  end
endmodule

// File: rtl/res_sign_fmt.sv
module res_sign_fmt
  import res_sign_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [RAW_W-1:0]  raw,
  input  logic [2:0]        res_sel,
  input  logic [1:0]        sign_policy,
  input  logic              is_diff,
  input  logic [CHAN_W-1:0] chan,
  input  logic              tag_en,
  output logic              out_valid,
  output logic [RAW_W-1:0]  result,
  output logic [WORD_W-1:0] last_word
);
  localparam int TAG_MSB = TAG_LSB + CHAN_W - 1;

  logic             signed_sel;
  logic [RAW_W-1:0] ext_val;
  logic [WORD_W-1:0] word_nxt;

  res_sign_decide u_decide (
    .policy   (sign_policy),
    .is_diff  (is_diff),
    .is_signed(signed_sel)
  );

  res_width_extend #(.W(RAW_W)) u_ext (
    .raw      (raw),
    .res_sel  (res_sel),
    .is_signed(signed_sel),
    .ext      (ext_val)
  );

  always_comb begin
    word_nxt = '0;
    word_nxt[RAW_W-1:0] = ext_val;
    if (tag_en) word_nxt[TAG_MSB:TAG_LSB] = chan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      last_word <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= ext_val;
        last_word <= word_nxt;
      end
    end
  end
endmodule

// File: rtl/res_sign_fmt_chk.sv
module res_sign_fmt_chk
  import res_sign_fmt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [RAW_W-1:0]  raw,
  input logic [2:0]        res_sel,
  input logic [1:0]        sign_policy,
  input logic              is_diff,
  input logic              out_valid,
  input logic [RAW_W-1:0]  result,
  input logic [WORD_W-1:0] last_word
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    seen |-> (out_valid == $past(in_valid))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(in_valid)) |-> $stable(result)); // R9

  AST_WORD_LOW_MATCH: assert property (@(posedge clk) disable iff (rst)
    last_word[RAW_W-1:0] == result); // R8

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (last_word[23:16] == 8'h00) && (last_word[31:28] == 4'h0)); // R8

  AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && res_sel >= 3'd4) |=> (result == $past(raw))); // R7

  AST_UNSIGNED_TOP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sign_policy == 2'd2 && res_sel == 3'd0) |=> (result[15:8] == 8'h00)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0 && last_word == '0)); // R1
endmodule

bind res_sign_fmt res_sign_fmt_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .raw(raw), .res_sel(res_sel),
  .sign_policy(sign_policy), .is_diff(is_diff), .out_valid(out_valid),
  .result(result), .last_word(last_word)
);

// File: tb/test_res_sign_fmt.sv
`timescale 1ns/1ps
module test_res_sign_fmt;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] raw = '0;
  logic [2:0] res_sel = '0;
  logic [1:0] sign_policy = '0;
  logic is_diff = 1'b0;
  logic [3:0] chan = '0;
  logic tag_en = 1'b0;
  logic out_valid;
  logic [15:0] result;
  logic [31:0] last_word;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  res_sign_fmt i_res_sign_fmt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw(raw), .res_sel(res_sel),
    .sign_policy(sign_policy), .is_diff(is_diff), .chan(chan), .tag_en(tag_en),
    .out_valid(out_valid), .result(result), .last_word(last_word)
  );

  function automatic bit ref_signed(input logic [1:0] p, input logic d);
    case (p)
      2'd0: return d;
      2'd1: return !d;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int ref_width(input logic [2:0] r);
    case (r)
      3'd0: return 8;
      3'd1: return 10;
      3'd2: return 12;
      3'd3: return 14;
      default: return 16;
    endcase
  endfunction

  function automatic logic [15:0] ref_result(input logic [15:0] v, input logic [2:0] r,
                                             input logic [1:0] p, input logic d);
    int w = ref_width(r);
    logic [15:0] o = '0;
    bit s = ref_signed(p, d);
    for (int i = 0; i < 16; i++) begin
      if (i < w) o[i] = v[i];
      else       o[i] = s ? v[w-1] : 1'b0;
    end
    return o;
  endfunction

  function automatic logic [31:0] ref_word(input logic [15:0] res, input logic [3:0] c,
                                           input logic t);
    logic [31:0] o = '0;
    o[15:0] = res;
    if (t) o[27:24] = c;
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] exp_res = '0;
  logic [31:0] exp_word = '0;

  task automatic apply(input logic [15:0] v, input logic [2:0] r, input logic [1:0] p,
                       input logic d, input logic [3:0] c, input logic t, input string req);
    @(negedge clk);
    in_valid = 1'b1; raw = v; res_sel = r; sign_policy = p; is_diff = d; chan = c; tag_en = t;
    @(negedge clk);
    in_valid = 1'b0;
    exp_res = ref_result(v, r, p, d);
    exp_word = ref_word(exp_res, c, t);
    check({req, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, {16'd0, result}, {16'd0, exp_res});
    check({req, " R8 word"}, last_word, exp_word);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expected=done actual=timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", {16'd0, result}, 32'd0);
    check("R1 word", last_word, 32'd0);
    rst = 1'b0;

    // R5 example values, 12-bit, all signed
    apply(16'h0F43, 3'd2, 2'd3, 1'b0, 4'h5, 1'b1, "R5 neg12");
    check("R5 0xF43", {16'd0, result}, 32'h0000FF43);
    apply(16'h0467, 3'd2, 2'd3, 1'b0, 4'h5, 1'b1, "R5 pos12");
    check("R5 0x467", {16'd0, result}, 32'h00000467);
    // R3 policy 0/1 per channel type
    apply(16'h0080, 3'd0, 2'd0, 1'b0, 4'h1, 1'b0, "R3 p0 se");
    check("R3 p0 se unsigned", {16'd0, result}, 32'h00000080);
    apply(16'h0080, 3'd0, 2'd0, 1'b1, 4'h1, 1'b0, "R3 p0 df");
    check("R3 p0 df signed", {16'd0, result}, 32'h0000FF80);
    apply(16'h0200, 3'd1, 2'd1, 1'b0, 4'h2, 1'b1, "R3 p1 se");
    check("R3 p1 se signed", {16'd0, result}, 32'h0000FE00);
    apply(16'h0200, 3'd1, 2'd1, 1'b1, 4'h2, 1'b1, "R3 p1 df");
    check("R3 p1 df unsigned", {16'd0, result}, 32'h00000200);
    // R6 unsigned zero fill, R4 upper bits ignored
    apply(16'hFFFF, 3'd3, 2'd2, 1'b1, 4'hF, 1'b1, "R6 R4 u14");
    check("R6 u14", {16'd0, result}, 32'h00003FFF);
    apply(16'hA5A5, 3'd0, 2'd2, 1'b0, 4'h3, 1'b0, "R4 u8 junk");
    check("R4 junk ignored", {16'd0, result}, 32'h000000A5);
    // R7 16-bit passthrough, including codes 5..7
    apply(16'h8001, 3'd4, 2'd3, 1'b1, 4'h9, 1'b1, "R7 s16");
    check("R7 s16", {16'd0, result}, 32'h00008001);
    apply(16'h8001, 3'd7, 2'd2, 1'b0, 4'h9, 1'b1, "R7 code7");
    check("R7 code7", {16'd0, result}, 32'h00008001);
    // R8 tag off zeros field
    apply(16'h0012, 3'd0, 2'd2, 1'b0, 4'hC, 1'b0, "R8 tag off");
    check("R8 field zero", {28'd0, last_word[27:24]}, 32'd0);

    // R9 hold with idle cycles
    repeat (3) begin
      @(negedge clk);
      raw = 16'(($urandom));
      res_sel = 3'($urandom);
      chan = 4'($urandom);
      tag_en = 1'b1;
    end
    check("R9 valid low", {31'd0, out_valid}, 32'd0);
    check("R9 result held", {16'd0, result}, {16'd0, exp_res});
    check("R9 word held", last_word, exp_word);

    // random
    for (int k = 0; k < 200; k++) begin
      apply(16'($urandom), 3'($urandom % 8), 2'($urandom), 1'($urandom),
            4'($urandom), 1'($urandom), "R3 R4 R5 R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule